// File: doc/BRIEF.md
# Nine-Bit Receive Status Flags

This block keeps the status flags for a UART receiver whose characters carry a ninth "expansion" bit after the eight data bits. The bit sampler and the baud logic are outside the block. They report each finished character through a one-cycle strobe that comes with the data byte and the ninth bit. A separate strobe, with an error qualifier, reports each completed transfer item. Static configuration inputs select the character length, expansion handling, data comparison, the ninth-bit level to react on, the operating mode, an 8-bit address value and the number of items in a buffer.

Three sticky flags are produced.
- The expansion flag records that a character arrived with its ninth bit at the chosen level.
- The address flag records that such a character also carried the programmed address byte.
- The buffer flag records that the programmed number of error-free items completed in a mode that allows it.

Software clears a flag by writing a one to its bit in a write-only clear port. A flag that is set in the same cycle as its clear stays set.

Top module: `ninebit_rx_status`

## Requirements
- R1: After a synchronous reset, all three flags read 0 and the item counter is 0.
- R2: When `frm_valid` is high, `cfg_len9` is 1, `cfg_exp_en` is 1 and `frm_bit9` equals `cfg_det_lvl`, `flag_exp` is 1 from the next cycle on.
- R3: `flag_exp` does not become 1 on a character if `cfg_len9` is 0, `cfg_exp_en` is 0, or `frm_bit9` differs from `cfg_det_lvl`.
- R4: When the conditions of R2 hold, `cfg_cmp_en` is 1 and `frm_data` equals `cfg_addr`, `flag_id` is 1 from the next cycle on. The ninth bit takes no part in the byte comparison.
- R5: `flag_id` does not become 1 if any of `cfg_len9`, `cfg_exp_en` or `cfg_cmp_en` is 0, if the ninth bit is not at the selected level, or if the byte differs from `cfg_addr`.
- R6: In mode 2'b00 or 2'b11, the `cfg_items`-th consecutive error-free `item_evt` sets `flag_buf` in the following cycle, and counting restarts from zero. A `cfg_items` of 0 is treated as 1.
- R7: In mode 2'b01 or 2'b10, `flag_buf` is never set and the item counter is held at 0.
- R8: An `item_evt` with `item_err` high resets the item counter and does not set `flag_buf`.
- R9: Each flag stays at 1 until a clear write addresses it.
- R10: A clear write (`clr_wr` high) clears the flags whose `clr_mask` bits are 1: bit 0 for `flag_exp`, bit 1 for `flag_id`, bit 2 for `flag_buf`. Bits written as 0 leave their flags unchanged.
- R11: When a set event and a clear of the same flag fall in the same cycle, the flag ends up at 1.
- R12: `clr_rdata` always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len9 | input | 1 | Nine-bit character length selected |
| cfg_exp_en | input | 1 | Expansion bit handling enabled |
| cfg_cmp_en | input | 1 | Address comparison enabled |
| cfg_det_lvl | input | 1 | Ninth-bit level that triggers detection |
| cfg_mode | input | 2 | Operating mode |
| cfg_addr | input | 8 | Address byte to compare against |
| cfg_items | input | CNT_W | Items per buffer (0 means 1) |
| frm_valid | input | 1 | One-cycle strobe: character finished |
| frm_data | input | 8 | Received data byte |
| frm_bit9 | input | 1 | Received ninth bit |
| item_evt | input | 1 | One-cycle strobe: transfer item completed |
| item_err | input | 1 | The completed item had an error |
| clr_wr | input | 1 | Clear register write strobe |
| clr_mask | input | 3 | Write-one-to-clear bits |
| clr_rdata | output | 3 | Clear register read value |
| flag_exp | output | 1 | Sticky expansion-detect flag |
| flag_id | output | 1 | Sticky address-match flag |
| flag_buf | output | 1 | Sticky buffer-complete flag |

## Verification
Two functions can fall in the same cycle: a set event for a flag and a software clear that addresses that same flag. The bench provokes this by asserting `clr_wr`, with the flag's mask bit set, in the same cycle as a qualifying character strobe. It then judges the outcome one cycle later by requiring the flag to read 1. A clear that comes in a quiet cycle is checked separately to show it drops the flag. This proves that the clear itself works, and that only the set has priority.

// File: rtl/nb_status_pkg.sv
package nb_status_pkg;

    typedef enum logic [1:0] {
        MODE_UART     = 2'b00,
        MODE_ALT_A    = 2'b01,
        MODE_ALT_B    = 2'b10,
        MODE_AUTOBAUD = 2'b11
    } nb_mode_e;

    typedef struct packed {
        logic len9;
        logic exp_en;
        logic cmp_en;
        logic det_lvl;
    } nb_ctrl_t;

    localparam int FLAG_EXP  = 0;
    localparam int FLAG_ID   = 1;
    localparam int FLAG_BUF  = 2;
    localparam int NUM_FLAGS = 3;

    typedef logic [NUM_FLAGS-1:0] nb_flags_t;

    function automatic logic mode_counts_items(nb_mode_e m);
        return (m == MODE_UART) || (m == MODE_AUTOBAUD);
    endfunction

endpackage

// File: rtl/nb_frame_eval.sv
module nb_frame_eval
    import nb_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  nb_ctrl_t            ctrl,
    input  logic                frm_valid,
    input  logic [DATA_W-1:0]   frm_data,
    input  logic                frm_bit9,
    input  logic [DATA_W-1:0]   addr,
    output logic                exp_hit,
    output logic                id_hit
);
    logic level_ok;

    always_comb begin
        level_ok = ctrl.len9 && ctrl.exp_en && (frm_bit9 == ctrl.det_lvl);
        exp_hit  = frm_valid && level_ok;
        id_hit   = frm_valid && level_ok && ctrl.cmp_en && (frm_data == addr);
    end
endmodule

// File: rtl/nb_item_counter.sv
module nb_item_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic [CNT_W-1:0] target,
    input  logic             item_evt,
    input  logic             item_err,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] tgt;
    logic             reach;

    always_comb begin
        tgt     = (target == '0) ? ONE : target;
        cnt_inc = cnt_q + ONE;
        reach   = (cnt_inc >= tgt);
        done    = count_en && item_evt && !item_err && reach;
    end

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            cnt_q <= '0;
        end else if (item_evt) begin
            if (item_err || reach) cnt_q <= '0;
            else                   cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/nb_sticky_flag.sv
module nb_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/ninebit_rx_status.sv
module ninebit_rx_status
    import nb_status_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_len9,
    input  logic             cfg_exp_en,
    input  logic             cfg_cmp_en,
    input  logic             cfg_det_lvl,
    input  logic [1:0]       cfg_mode,
    input  logic [7:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_items,
    input  logic             frm_valid,
    input  logic [7:0]       frm_data,
    input  logic             frm_bit9,
    input  logic             item_evt,
    input  logic             item_err,
    input  logic             clr_wr,
    input  logic [2:0]       clr_mask,
    output logic [2:0]       clr_rdata,
    output logic             flag_exp,
    output logic             flag_id,
    output logic             flag_buf
);
    nb_ctrl_t  ctrl;
    nb_mode_e  mode;
    nb_flags_t set_vec;
    nb_flags_t clr_vec;
    nb_flags_t flags;
    logic      exp_hit, id_hit, buf_done, count_en;

    always_comb begin
        ctrl     = '{len9: cfg_len9, exp_en: cfg_exp_en,
                     cmp_en: cfg_cmp_en, det_lvl: cfg_det_lvl};
        mode     = nb_mode_e'(cfg_mode);
        count_en = mode_counts_items(mode);
    end

    nb_frame_eval #(.DATA_W(8)) u_eval (
        .ctrl      (ctrl),
        .frm_valid (frm_valid),
        .frm_data  (frm_data),
        .frm_bit9  (frm_bit9),
        .addr      (cfg_addr),
        .exp_hit   (exp_hit),
        .id_hit    (id_hit)
    );

    nb_item_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .target   (cfg_items),
        .item_evt (item_evt),
        .item_err (item_err),
        .done     (buf_done)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_EXP] = exp_hit;
        set_vec[FLAG_ID]  = id_hit;
        set_vec[FLAG_BUF] = buf_done;
        clr_vec           = clr_wr ? clr_mask : '0;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        nb_sticky_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (set_vec[g]),
            .clr (clr_vec[g]),
            .q   (flags[g])
        );
    end

    assign flag_exp  = flags[FLAG_EXP];
    assign flag_id   = flags[FLAG_ID];
    assign flag_buf  = flags[FLAG_BUF];
    assign clr_rdata = '0;
endmodule

// File: rtl/ninebit_rx_status_chk.sv
module ninebit_rx_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_len9,
    input logic       cfg_exp_en,
    input logic       cfg_cmp_en,
    input logic       cfg_det_lvl,
    input logic [1:0] cfg_mode,
    input logic [7:0] cfg_addr,
    input logic       frm_valid,
    input logic [7:0] frm_data,
    input logic       frm_bit9,
    input logic       clr_wr,
    input logic [2:0] clr_mask,
    input logic       flag_exp,
    input logic       flag_id,
    input logic       flag_buf
);
    p_exp_set_r2: assert property (@(posedge clk) disable iff (rst)
        frm_valid && cfg_len9 && cfg_exp_en && (frm_bit9 == cfg_det_lvl) |=> flag_exp);

    p_exp_gated_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_exp_en && !flag_exp |=> !flag_exp);

    p_id_source_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_id) |-> $past(frm_valid) && ($past(frm_data) == $past(cfg_addr)));

    p_id_gated_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_cmp_en && !flag_id |=> !flag_id);

    p_buf_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b01 || cfg_mode == 2'b10) && !flag_buf |=> !flag_buf);

    p_exp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        flag_exp && !(clr_wr && clr_mask[0]) |=> flag_exp);

    p_buf_hold_r9: assert property (@(posedge clk) disable iff (rst)
        flag_buf && !(clr_wr && clr_mask[2]) |=> flag_buf);

    p_id_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr_wr && clr_mask[1] && !frm_valid |=> !flag_id);
endmodule

bind ninebit_rx_status ninebit_rx_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_len9    (cfg_len9),
    .cfg_exp_en  (cfg_exp_en),
    .cfg_cmp_en  (cfg_cmp_en),
    .cfg_det_lvl (cfg_det_lvl),
    .cfg_mode    (cfg_mode),
    .cfg_addr    (cfg_addr),
    .frm_valid   (frm_valid),
    .frm_data    (frm_data),
    .frm_bit9    (frm_bit9),
    .clr_wr      (clr_wr),
    .clr_mask    (clr_mask),
    .flag_exp    (flag_exp),
    .flag_id     (flag_id),
    .flag_buf    (flag_buf)
);

// File: tb/test_ninebit_rx_status.sv
module test_ninebit_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_len9, cfg_exp_en, cfg_cmp_en, cfg_det_lvl;
    logic [1:0]       cfg_mode;
    logic [7:0]       cfg_addr;
    logic [CNT_W-1:0] cfg_items;
    logic             frm_valid;
    logic [7:0]       frm_data;
    logic             frm_bit9;
    logic             item_evt, item_err;
    logic             clr_wr;
    logic [2:0]       clr_mask;
    logic [2:0]       clr_rdata;
    logic             flag_exp, flag_id, flag_buf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ninebit_rx_status #(.CNT_W(CNT_W)) i_ninebit_rx_status (.*);

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] m);
        clr_wr = 1'b1; clr_mask = m;
        #1;
        checks++;
        if (clr_rdata !== 3'b000) begin
            errors++;
            $display("FAIL R12 clr_rdata: actual %0b expected 0", clr_rdata);
        end
        tick();
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic frame(input logic [7:0] d, input logic b9);
        frm_valid = 1'b1; frm_data = d; frm_bit9 = b9;
        tick();
        frm_valid = 1'b0;
    endtask

    task automatic items(input int n, input logic err);
        for (int k = 0; k < n; k++) begin
            item_evt = 1'b1; item_err = err;
            tick();
            item_evt = 1'b0; item_err = 1'b0;
        end
    endtask

    task automatic flush_counter();
        cfg_mode = 2'b01;
        tick();
    endtask

    initial begin
        rst = 1'b1;
        {cfg_len9, cfg_exp_en, cfg_cmp_en, cfg_det_lvl} = '0;
        cfg_mode = 2'b00; cfg_addr = '0; cfg_items = '0;
        frm_valid = 0; frm_data = '0; frm_bit9 = 0;
        item_evt = 0; item_err = 0; clr_wr = 0; clr_mask = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        check(flag_exp, 1'b0, "R1", "reset flag_exp");
        check(flag_id,  1'b0, "R1", "reset flag_id");
        check(flag_buf, 1'b0, "R1", "reset flag_buf");
        // counter is 0 after reset: two items needed
        cfg_items = 4'd2;
        items(1, 1'b0);
        check(flag_buf, 1'b0, "R1", "first item after reset");
        items(1, 1'b0);
        check(flag_buf, 1'b1, "R1", "second item after reset");
        clear(3'b111);

        // exhaustive sweep of the character qualifiers
        for (int c = 0; c < 16; c++) begin
            for (int b = 0; b < 2; b++) begin
                for (int mt = 0; mt < 2; mt++) begin
                    logic el, il;
                    logic [7:0] id;
                    {cfg_len9, cfg_exp_en, cfg_cmp_en, cfg_det_lvl} = 4'(c);
                    id = 8'hA5 ^ 8'(c * 7);
                    cfg_addr = id;
                    clear(3'b011);
                    frame(mt[0] ? id : (id ^ 8'h10), b[0]);
                    el = cfg_len9 & cfg_exp_en & (b[0] == cfg_det_lvl);
                    il = el & cfg_cmp_en & mt[0];
                    check(flag_exp, el, el ? "R2" : "R3", $sformatf("exp cfg=%0h b9=%0d", c, b));
                    check(flag_id,  il, il ? "R4" : "R5", $sformatf("id cfg=%0h b9=%0d m=%0d", c, b, mt));
                end
            end
        end

        // buffer completion over modes and item counts
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 5; n++) begin
                int tgt;
                logic counts;
                flush_counter();
                cfg_mode = 2'(m);
                cfg_items = CNT_W'(n);
                clear(3'b100);
                tgt = (n == 0) ? 1 : n;
                counts = (m == 0) || (m == 3);
                items(tgt - 1, 1'b0);
                check(flag_buf, 1'b0, counts ? "R6" : "R7", $sformatf("m=%0d n=%0d early", m, n));
                items(1, 1'b0);
                check(flag_buf, counts, counts ? "R6" : "R7", $sformatf("m=%0d n=%0d last", m, n));
            end
        end

        // restart after completion
        flush_counter();
        cfg_mode = 2'b11; cfg_items = 4'd3;
        items(3, 1'b0);
        clear(3'b100);
        items(2, 1'b0);
        check(flag_buf, 1'b0, "R6", "restart partial");
        items(1, 1'b0);
        check(flag_buf, 1'b1, "R6", "restart complete");
        clear(3'b100);

        // error resets count
        items(2, 1'b0);
        items(1, 1'b1);
        check(flag_buf, 1'b0, "R8", "errored item");
        items(2, 1'b0);
        check(flag_buf, 1'b0, "R8", "two after error");
        items(1, 1'b0);
        check(flag_buf, 1'b1, "R8", "three after error");
        clear(3'b100);

        // sticky and selective clears
        {cfg_len9, cfg_exp_en, cfg_cmp_en, cfg_det_lvl} = 4'b1111;
        cfg_addr = 8'h3C;
        frame(8'h3C, 1'b1);
        for (int k = 0; k < 5; k++) tick();
        check(flag_exp, 1'b1, "R9", "exp held");
        check(flag_id,  1'b1, "R9", "id held");
        clear(3'b000);
        check(flag_exp, 1'b1, "R10", "zero mask keeps exp");
        check(flag_id,  1'b1, "R10", "zero mask keeps id");
        clear(3'b010);
        check(flag_id,  1'b0, "R10", "bit1 clears id");
        check(flag_exp, 1'b1, "R10", "bit1 keeps exp");
        clear(3'b001);
        check(flag_exp, 1'b0, "R10", "bit0 clears exp");

        // set and clear in the same cycle
        clr_wr = 1'b1; clr_mask = 3'b011;
        frame(8'h3C, 1'b1);
        clr_wr = 1'b0; clr_mask = '0;
        check(flag_exp, 1'b1, "R11", "exp set beats clear");
        check(flag_id,  1'b1, "R11", "id set beats clear");
        cfg_items = 4'd1;
        clr_wr = 1'b1; clr_mask = 3'b100;
        items(1, 1'b0);
        clr_wr = 1'b0; clr_mask = '0;
        check(flag_buf, 1'b1, "R11", "buf set beats clear");
        clear(3'b111);
        check(flag_buf, 1'b0, "R10", "bit2 clears buf");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule